// File: doc/BRIEF.md
# Windowed Three-State Phase-Frequency Detector

This block compares two single-cycle strobe streams that share one system clock: a reference stream and a divided-oscillator stream. A classic three-state detector remembers which stream fired first. While only one side is pending, the block drives a coarse correction output. The output is built from an enable and a polarity. Polarity 1 means drive high, which happens when the oscillator edge came first. Polarity 0 means drive low, which happens when the reference edge came first. Enable 0 means the output is at high impedance.

A pair completes in the cycle in which the trailing strobe is sampled. The phase error of that pair is the number of clock cycles between the two strobes. If the error is no larger than a programmable window, the block asserts an active-low lock flag and keeps the coarse output at high impedance for short pending intervals. If a pending interval grows past the window, the coarse output drives again so that the loop can be pulled back quickly.

Top module: `pfd_lock`

## Requirements
- R1: After a synchronous active-high reset, `lock_n` is 1 and `coarse_en` is 0.
- R2: With no pair pending, an oscillator strobe alone marks the oscillator side pending from the next clock. While it is pending and the block is unlocked, `coarse_en`=1 and `coarse_pol`=1.
- R3: With no pair pending, a reference strobe alone marks the reference side pending from the next clock. While it is pending and the block is unlocked, `coarse_en`=1 and `coarse_pol`=0.
- R4: A pair completes at the clock edge that samples the trailing strobe, and `coarse_en` is 0 after that edge. Strobes that arrive together on both inputs while nothing is pending form a pair with error 0 and cause no drive at all.
- R5: The error of a pair is d, where d is the number of clock edges from the edge that sampled the leading strobe to the edge that sampled the trailing strobe. After completion, `lock_n` is 0 if d <= `win_cfg`, and 1 otherwise.
- R6: `lock_n` changes only at a clock edge that completes a pair, or at reset.
- R7: Suppose the block is locked and one side has been pending for j clock edges past the leading edge (j=0 right after it). Then `coarse_en` is 1 exactly when j+1 > `win_cfg`.
- R8: The error measurement saturates at 2^CNT_W-1 and does not wrap. A very long pending interval therefore always ends unlocked and keeps the coarse output driving.
- R9: A repeated strobe on the already-pending side has no effect. The error is still measured from the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_stb | input | 1 | Reference edge strobe, one cycle wide |
| vco_stb | input | 1 | Divided-oscillator edge strobe, one cycle wide |
| win_cfg | input | WIN_W | Lock window in clock cycles |
| coarse_en | output | 1 | 1 = coarse output driven, 0 = high impedance |
| coarse_pol | output | 1 | 1 = drive high (oscillator leads), 0 = drive low |
| lock_n | output | 1 | 0 = locked, 1 = released |

## Verification
The bench builds the block with CNT_W=5 and the default WIN_W=4. It sweeps every window value from 0 to 15 against every signed offset from -18 to 18. This covers both polarities, coincident strobes, and each window boundary, checking both the locked and unlocked history. The small counter width puts the saturation point within reach: offsets of 35 and 40 would wrap to small errors if the counter were not clamped.

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int CNT_W = 6,
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_stb,
  input  logic             vco_stb,
  input  logic [WIN_W-1:0] win_cfg,
  output logic             coarse_en,
  output logic             coarse_pol,
  output logic             lock_n
);
  localparam int EW = CNT_W + 1;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic             up, dn, locked;
  logic [CNT_W-1:0] cnt;

  wire            pend    = up | dn;
  wire            u_nx    = up | vco_stb;
  wire            d_nx    = dn | ref_stb;
  wire            pair    = u_nx & d_nx;
  wire [EW-1:0]   elapsed = {1'b0, cnt} + 1'b1;
  wire [EW-1:0]   err     = pend ? elapsed : '0;
  wire [EW-1:0]   win_x   = EW'(win_cfg);

  assign coarse_en  = pend & (~locked | (elapsed > win_x));
  assign coarse_pol = up;
  assign lock_n     = ~locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      up     <= 1'b0;
      dn     <= 1'b0;
      locked <= 1'b0;
      cnt    <= '0;
    end else if (pair) begin
      up     <= 1'b0;
      dn     <= 1'b0;
      cnt    <= '0;
      locked <= (err <= win_x);
    end else begin
      up <= u_nx;
      dn <= d_nx;
      if (!pend)
        cnt <= '0;
      else if (cnt != CMAX)
        cnt <= cnt + 1'b1;
    end
  end
endmodule

module pfd_lock_chk (
  input logic clk,
  input logic rst,
  input logic ref_stb,
  input logic vco_stb,
  input logic up,
  input logic dn,
  input logic coarse_en,
  input logic lock_n
);
  wire done = (up | vco_stb) & (dn | ref_stb);

  p_reset_state_r1: assert property (@(posedge clk) rst |=> (lock_n && !coarse_en));

  p_vco_pending_r2: assert property (@(posedge clk) disable iff (rst)
    (!up && !dn && vco_stb && !ref_stb) |=> (up && !dn));

  p_ref_pending_r3: assert property (@(posedge clk) disable iff (rst)
    (!up && !dn && ref_stb && !vco_stb) |=> (dn && !up));

  p_coincident_r4: assert property (@(posedge clk) disable iff (rst)
    (!up && !dn && ref_stb && vco_stb) |=> (!up && !dn && !coarse_en && !lock_n));

  p_lock_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(lock_n));

  p_one_side_r9: assert property (@(posedge clk) disable iff (rst) !(up && dn));
endmodule

bind pfd_lock pfd_lock_chk u_chk (
  .clk(clk), .rst(rst), .ref_stb(ref_stb), .vco_stb(vco_stb),
  .up(up), .dn(dn), .coarse_en(coarse_en), .lock_n(lock_n)
);

// File: tb/pfd_lock_test.sv
module pfd_lock_test;
  logic clk = 0, rst = 1, ref_stb = 0, vco_stb = 0;
  logic [3:0] win_cfg = 0;
  logic coarse_en, coarse_pol, lock_n;
  int checks = 0, failures = 0;
  bit lk = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pfd_lock #(.CNT_W(5), .WIN_W(4)) uut (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .vco_stb(vco_stb),
    .win_cfg(win_cfg), .coarse_en(coarse_en), .coarse_pol(coarse_pol),
    .lock_n(lock_n)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (win=%0d)", req, act, exp, win_cfg);
    end
  endtask

  // d>0: oscillator leads by d; d<0: reference leads; 0: coincident
  task automatic run_pair(int d, bit extra);
    int ad = (d < 0) ? -d : d;
    int eff;
    @(negedge clk);
    vco_stb = (d >= 0);
    ref_stb = (d <= 0);
    @(negedge clk);
    vco_stb = 0; ref_stb = 0;
    if (d == 0) begin
      chk("R4 coincident en", coarse_en, 0);
      chk("R4 coincident lock_n", lock_n, 0);
      lk = 1;
      return;
    end
    for (int j = 0; j < ad; j++) begin
      chk(d > 0 ? "R2/R7 en" : "R3/R7 en", coarse_en,
          (!lk || (j + 1 > win_cfg)) ? 1 : 0);
      if (coarse_en) chk(d > 0 ? "R2 pol" : "R3 pol", coarse_pol, d > 0);
      chk("R6 lock_n steady", lock_n, !lk);
      if (j < ad - 1) begin
        if (extra && j == 0) begin
          if (d > 0) vco_stb = 1; else ref_stb = 1;
        end
        @(negedge clk);
        vco_stb = 0; ref_stb = 0;
      end
    end
    if (d > 0) ref_stb = 1; else vco_stb = 1;
    @(negedge clk);
    vco_stb = 0; ref_stb = 0;
    eff = (ad > 31) ? 31 : ad;
    lk = (eff <= win_cfg);
    chk(ad > 31 ? "R8 saturate lock_n" : (extra ? "R9 repeat lock_n" : "R5 lock_n"),
        lock_n, !lk);
    chk("R4 released after pair", coarse_en, 0);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 lock_n", lock_n, 1);
    chk("R1 coarse_en", coarse_en, 0);
    lk = 0;
    for (int w = 0; w < 16; w++) begin
      win_cfg = w[3:0];
      for (int d = -18; d <= 18; d++) run_pair(d, 0);
    end
    win_cfg = 6;
    run_pair(0, 0);
    run_pair(5, 1);
    run_pair(-5, 1);
    run_pair(9, 1);
    run_pair(-3, 1);
    win_cfg = 15;
    run_pair(2, 0);
    run_pair(35, 0);
    run_pair(3, 0);
    run_pair(-40, 0);
    run_pair(0, 0);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 lock_n after reset", lock_n, 1);
    chk("R1 coarse_en after reset", coarse_en, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule